// File: doc/BRIEF.md
# Packed Lane Arithmetic Unit

This block is a 64-bit packed-integer arithmetic stage. Each cycle it can accept a destination operand, a source operand, an operation code and a lane-size code, and one cycle later it presents a 64-bit result with a valid flag. The word is treated as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The selected lane size sets where carries stop, which bits saturation clamps and how wide each compare mask is.

The unit supports several operation families:

- plain wrap-around addition and subtraction;
- saturating addition and subtraction, signed or unsigned, on 8-bit and 16-bit lanes;
- lane-wise equality and signed greater-than compares that return all-ones or all-zero lanes;
- four whole-word bitwise operations.

Subtraction and compares always take the destination as the left operand. Any combination of operation and lane size outside the supported set returns zero.

The unit sits inside a datapath that issues one operation per cycle. The result register loads only on cycles where the input is marked valid, and it keeps its value on all other cycles.

Top module: `simd_lane_alu`

## Requirements
- R1: With `op_code` 0, each lane holds dst + src modulo 2^w, where w is the lane width. No carry crosses a lane boundary. The `lane_sz` code 0/1/2/3 selects 8/16/32/64-bit lanes, and lane k occupies bits [k*w+w-1 : k*w].
- R2: With `op_code` 1, each lane holds dst − src modulo 2^w, with no borrow crossing a lane boundary.
- R3: With `op_code` 2 (add) or 3 (dst − src) on 8-bit or 16-bit lanes, the operands are treated as signed. A lane whose true result is above 2^(w−1)−1 gives that value, and a lane below −2^(w−1) gives −2^(w−1).
- R4: With `op_code` 4 (add) or 5 (dst − src) on 8-bit or 16-bit lanes, the operands are treated as unsigned. An add lane that exceeds 2^w−1 gives all ones, and a subtract lane that would go below zero gives zero.
- R5: With `op_code` 6 on 8/16/32-bit lanes, each lane is all ones when dst and src are equal in that lane, and zero otherwise.
- R6: With `op_code` 7 on 8/16/32-bit lanes, each lane is all ones when dst is greater than src, both read as signed two's-complement values. Otherwise the lane is zero.
- R7: `op_code` 8/9/10/11 give dst&src, (~dst)&src, dst|src and dst^src on the whole word. `lane_sz` has no effect on these operations.
- R8: The result is all zeros for `op_code` 2–5 with 32-bit or 64-bit lanes, for `op_code` 6–7 with 64-bit lanes, and for `op_code` 12–15.
- R9: `out_valid` equals `in_valid` delayed by one clock. An operation presented with `in_valid` high appears on `result` after the next rising edge. Driving `rst_n` low clears `out_valid` at once; release is synchronised to the clock.
- R10: While `in_valid` is low, `result` keeps its last loaded value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| op_code | input | 4 | Operation select (see R1–R8) |
| lane_sz | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| dst | input | 64 | Destination (left) operand |
| src | input | 64 | Source (right) operand |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered lane-wise result |

## Verification
The bench covers every pair of `op_code` and `lane_sz`, all 64 of them. Each pair gets vectors whose bytes are drawn mostly from boundary values (00, 01, 7F, 80, 81, FE, FF) with random bytes mixed in.

- The boundary bytes place carries, borrows and signed overflow right at lane edges. They therefore distinguish a carry cut at the correct boundary from one cut a lane too early or too late, and signed clamping from unsigned clamping.
- Every fifth vector copies src from dst, so the equality and greater-than tests see both outcomes even on 32-bit lanes.
- The illegal pairs are expected to give zero.

A short hold sequence and a mid-run reset check the timing of the valid flag and the register.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDS  = 4'd2,
    OP_SUBS  = 4'd3,
    OP_ADDUS = 4'd4,
    OP_SUBUS = 4'd5,
    OP_CMPEQ = 4'd6,
    OP_CMPGT = 4'd7,
    OP_AND   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_64 = 2'd3
  } lane_sz_e;

  typedef enum logic [1:0] {
    SEL_ARITH = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_LOGIC = 2'd2,
    SEL_ZERO  = 2'd3
  } res_sel_e;

  typedef struct packed {
    logic     sub;     // invert source and inject carry at each lane start
    logic     sat_s;   // clamp on signed overflow
    logic     sat_u;   // clamp on unsigned carry/borrow
    logic     cmp_gt;  // compare flavour: 1 = greater-than, 0 = equal
    res_sel_e sel;
  } ctl_t;

  // Byte-index mask of a lane: low bits set for bytes inside one lane.
  function automatic logic [7:0] lane_mask_f(lane_sz_e sz);
    logic [7:0] m;
    m = '0;
    for (int k = 0; k < 3; k++) begin
      if (k < int'(sz)) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
  import simd_alu_pkg::*;
(
  input  logic [3:0] op_code,
  input  lane_sz_e   lane_sz,
  output ctl_t       ctl
);

  logic narrow_lane;   // 8 or 16 bit lanes
  logic not_full;      // anything but one 64-bit lane

  always_comb begin
    narrow_lane = (lane_sz == LS_8) || (lane_sz == LS_16);
    not_full    = (lane_sz != LS_64);
    ctl         = '{sub: 1'b0, sat_s: 1'b0, sat_u: 1'b0, cmp_gt: 1'b0, sel: SEL_ZERO};
    case (op_code)
      OP_ADD:   ctl.sel = SEL_ARITH;
      OP_SUB:   begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; end
      OP_ADDS:  begin ctl.sat_s = 1'b1; ctl.sel = narrow_lane ? SEL_ARITH : SEL_ZERO; end
      OP_SUBS:  begin ctl.sat_s = 1'b1; ctl.sub = 1'b1;
                      ctl.sel = narrow_lane ? SEL_ARITH : SEL_ZERO; end
      OP_ADDUS: begin ctl.sat_u = 1'b1; ctl.sel = narrow_lane ? SEL_ARITH : SEL_ZERO; end
      OP_SUBUS: begin ctl.sat_u = 1'b1; ctl.sub = 1'b1;
                      ctl.sel = narrow_lane ? SEL_ARITH : SEL_ZERO; end
      OP_CMPEQ: begin ctl.sub = 1'b1; ctl.sel = not_full ? SEL_CMP : SEL_ZERO; end
      OP_CMPGT: begin ctl.sub = 1'b1; ctl.cmp_gt = 1'b1;
                      ctl.sel = not_full ? SEL_CMP : SEL_ZERO; end
      OP_AND, OP_ANDN, OP_OR, OP_XOR: ctl.sel = SEL_LOGIC;
      default:  ctl.sel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0]        a,
  input  logic [WORD_W-1:0]        b,
  input  logic                     sub,
  input  lane_sz_e                 lane_sz,
  output logic [WORD_W-1:0]        sum,
  output logic [WORD_W/BYTE_W-1:0] cout
);

  localparam int N_BYTES = WORD_W / BYTE_W;
  localparam int BIDX_W  = $clog2(N_BYTES);

  logic [BIDX_W-1:0] lane_mask;
  assign lane_mask = BIDX_W'(lane_mask_f(lane_sz));

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] b_eff;
    logic              lane_start;
    logic              cin;

    assign b_eff      = sub ? ~b[i*BYTE_W +: BYTE_W] : b[i*BYTE_W +: BYTE_W];
    assign lane_start = ((BIDX_W'(i) & lane_mask) == '0);

    if (i == 0) begin : g_first
      assign cin = sub;
    end else begin : g_rest
      // carry chain is cut where a new lane begins
      assign cin = lane_start ? sub : cout[i-1];
    end

    assign {cout[i], sum[i*BYTE_W +: BYTE_W]} =
      {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, b_eff} + {{BYTE_W{1'b0}}, cin};
  end

endmodule

// File: rtl/simd_lane_post.sv
module simd_lane_post
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0]        a,
  input  logic [WORD_W-1:0]        b,
  input  logic [WORD_W-1:0]        sum,
  input  logic [WORD_W/BYTE_W-1:0] cout,
  input  lane_sz_e                 lane_sz,
  input  ctl_t                     ctl,
  output logic [WORD_W-1:0]        arith_res,
  output logic [WORD_W-1:0]        cmp_res
);

  localparam int N_BYTES = WORD_W / BYTE_W;
  localparam int BIDX_W  = $clog2(N_BYTES);

  logic [BIDX_W-1:0]  lane_mask;
  logic [N_BYTES-1:0] a_msb_b, beff_msb_b, r_msb_b, ovf_s_b, ovf_u_b, eq_b;

  assign lane_mask = BIDX_W'(lane_mask_f(lane_sz));

  // Per-byte flags; only the flags of a lane's top byte are consumed.
  for (genvar i = 0; i < N_BYTES; i++) begin : g_flag
    assign a_msb_b[i]    = a[i*BYTE_W + BYTE_W-1];
    assign beff_msb_b[i] = b[i*BYTE_W + BYTE_W-1] ^ ctl.sub;
    assign r_msb_b[i]    = sum[i*BYTE_W + BYTE_W-1];
    assign ovf_s_b[i]    = (a_msb_b[i] == beff_msb_b[i]) && (r_msb_b[i] != a_msb_b[i]);
    assign ovf_u_b[i]    = cout[i] ^ ctl.sub;
    assign eq_b[i]       = (a[i*BYTE_W +: BYTE_W] == b[i*BYTE_W +: BYTE_W]);
  end

  for (genvar i = 0; i < N_BYTES; i++) begin : g_out
    logic [BIDX_W-1:0] top_idx;
    logic              is_top;
    logic              neg_side;
    logic              lane_eq;
    logic              lane_gt;

    assign top_idx  = BIDX_W'(i) | lane_mask;
    assign is_top   = (BIDX_W'(i) == top_idx);
    assign neg_side = a_msb_b[top_idx];

    always_comb begin
      lane_eq = 1'b1;
      for (int j = 0; j < N_BYTES; j++) begin
        if (((BIDX_W'(j) | lane_mask) == top_idx) && !eq_b[j]) lane_eq = 1'b0;
      end
    end

    // true sign of (a - b) is result sign corrected by signed overflow
    assign lane_gt = !lane_eq && !(r_msb_b[top_idx] ^ ovf_s_b[top_idx]);

    always_comb begin
      if (ctl.sat_s && ovf_s_b[top_idx]) begin
        arith_res[i*BYTE_W +: BYTE_W] = is_top ? {neg_side, {(BYTE_W-1){~neg_side}}}
                                               : {BYTE_W{~neg_side}};
      end else if (ctl.sat_u && ovf_u_b[top_idx]) begin
        arith_res[i*BYTE_W +: BYTE_W] = {BYTE_W{~ctl.sub}};
      end else begin
        arith_res[i*BYTE_W +: BYTE_W] = sum[i*BYTE_W +: BYTE_W];
      end
    end

    assign cmp_res[i*BYTE_W +: BYTE_W] = {BYTE_W{ctl.cmp_gt ? lane_gt : lane_eq}};
  end

endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise #(
  parameter int WORD_W = 64
) (
  input  logic [3:0]        op_code,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y
);
  import simd_alu_pkg::*;

  always_comb begin
    case (op_code)
      OP_AND:  y = a & b;
      OP_ANDN: y = ~a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        lane_sz,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] src,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);

  localparam int N_BYTES = WORD_W / BYTE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rs_n = rst_sync[1];

  lane_sz_e           sz;
  ctl_t               ctl;
  logic [WORD_W-1:0]  sum, arith_res, cmp_res, logic_res;
  logic [N_BYTES-1:0] cout;

  assign sz = lane_sz_e'(lane_sz);

  simd_op_decode u_dec (
    .op_code (op_code),
    .lane_sz (sz),
    .ctl     (ctl)
  );

  simd_seg_adder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_add (
    .a       (dst),
    .b       (src),
    .sub     (ctl.sub),
    .lane_sz (sz),
    .sum     (sum),
    .cout    (cout)
  );

  simd_lane_post #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_post (
    .a         (dst),
    .b         (src),
    .sum       (sum),
    .cout      (cout),
    .lane_sz   (sz),
    .ctl       (ctl),
    .arith_res (arith_res),
    .cmp_res   (cmp_res)
  );

  simd_bitwise #(.WORD_W(WORD_W)) u_bit (
    .op_code (op_code),
    .a       (dst),
    .b       (src),
    .y       (logic_res)
  );

  // next-state
  logic [WORD_W-1:0] res_d;
  logic              valid_d;

  always_comb begin
    case (ctl.sel)
      SEL_ARITH: res_d = arith_res;
      SEL_CMP:   res_d = cmp_res;
      SEL_LOGIC: res_d = logic_res;
      default:   res_d = '0;
    endcase
    valid_d = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) out_valid <= 1'b0;
    else       out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) result <= res_d;
  end

  AST_WRAP_ZERO_SRC: assert property (@(posedge clk) disable iff (!rs_n)
    (in_valid && op_code == OP_ADD && src == '0) |=> (result == $past(dst))); // R1
  AST_USUB_FLOOR: assert property (@(posedge clk) disable iff (!rs_n)
    (in_valid && op_code == OP_SUBUS && lane_sz <= 2'd1 && dst == '0) |=> (result == '0)); // R4
  AST_UADD_CEIL: assert property (@(posedge clk) disable iff (!rs_n)
    (in_valid && op_code == OP_ADDUS && lane_sz <= 2'd1 && dst == '1) |=> (result == '1)); // R4
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rs_n)
    (in_valid && op_code == OP_CMPEQ && lane_sz != 2'd3 && dst == src) |=> (result == '1)); // R5
  AST_XOR_SELF: assert property (@(posedge clk) disable iff (!rs_n)
    (in_valid && op_code == OP_XOR && dst == src) |=> (result == '0)); // R7
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rs_n)
    in_valid |=> out_valid); // R9
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rs_n)
    !in_valid |=> !out_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rs_n)
    (!in_valid && out_valid) |=> $stable(result)); // R10

endmodule

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic [1:0]  lane_sz;
  logic [63:0] dst, src;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  simd_lane_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .lane_sz(lane_sz), .dst(dst), .src(src), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string req_of(logic [3:0] op, logic [1:0] sz);
    if (op >= 4'd12) return "R8";
    if (op >= 4'd2 && op <= 4'd5 && sz >= 2'd2) return "R8";
    if ((op == 4'd6 || op == 4'd7) && sz == 2'd3) return "R8";
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [63:0] ref_calc(logic [3:0] op, logic [1:0] sz,
                                          logic [63:0] d, logic [63:0] s);
    int w, nl;
    logic [63:0] r, lv;
    logic [65:0] ua, ub, ut;
    logic signed [65:0] sa, sb, st, smax, smin;
    w  = 8 << sz;
    nl = 64 / w;
    r  = '0;
    case (op)
      4'd8:  return d & s;
      4'd9:  return ~d & s;
      4'd10: return d | s;
      4'd11: return d ^ s;
      default: ;
    endcase
    if (req_of(op, sz) == "R8") return '0;
    for (int k = 0; k < nl; k++) begin
      ua = '0; ub = '0;
      for (int b = 0; b < w; b++) begin
        ua[b] = d[k*w + b];
        ub[b] = s[k*w + b];
      end
      sa = $signed(ua); sb = $signed(ub);
      if (ua[w-1]) sa = sa - (66'sd1 <<< w);
      if (ub[w-1]) sb = sb - (66'sd1 <<< w);
      smax = (66'sd1 <<< (w-1)) - 66'sd1;
      smin = -(66'sd1 <<< (w-1));
      lv = '0;
      case (op)
        4'd0: begin ut = ua + ub; lv = ut[63:0]; end
        4'd1: begin ut = ua - ub; lv = ut[63:0]; end
        4'd2, 4'd3: begin
          st = (op == 4'd2) ? sa + sb : sa - sb;
          if (st > smax) st = smax;
          if (st < smin) st = smin;
          lv = st[63:0];
        end
        4'd4: begin
          ut = ua + ub;
          if (ut > ((66'd1 << w) - 66'd1)) ut = (66'd1 << w) - 66'd1;
          lv = ut[63:0];
        end
        4'd5: begin
          if (ub > ua) lv = '0;
          else begin ut = ua - ub; lv = ut[63:0]; end
        end
        4'd6: lv = (ua == ub) ? '1 : '0;
        4'd7: lv = (sa > sb) ? '1 : '0;
        default: lv = '0;
      endcase
      for (int b = 0; b < w; b++) r[k*w + b] = lv[b];
    end
    return r;
  endfunction

  function automatic logic [7:0] pick_byte();
    logic [31:0] rv;
    rv = $urandom;
    if (rv[31:29] == 3'b000) return rv[7:0];
    case (rv[2:0])
      3'd0: return 8'h00;
      3'd1: return 8'h01;
      3'd2: return 8'h7F;
      3'd3: return 8'h80;
      3'd4: return 8'h81;
      3'd5: return 8'hFE;
      3'd6: return 8'hFF;
      default: return rv[15:8];
    endcase
  endfunction

  function automatic logic [63:0] pick_word();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = pick_byte();
    return v;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%016h expected=%016h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [1:0] sz, logic [63:0] d, logic [63:0] s);
    logic [63:0] exp;
    exp = ref_calc(op, sz, d, s);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; lane_sz = sz; dst = d; src = s;
    @(negedge clk);
    check(req_of(op, sz), $sformatf("op=%0d sz=%0d d=%016h s=%016h", op, sz, d, s), result, exp);
    check("R9", "out_valid after load", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    logic [63:0] held, d0, s0;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; lane_sz = '0; dst = '0; src = '0;
    repeat (4) @(negedge clk);
    check("R9", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", "out_valid idle after reset", {63'd0, out_valid}, 64'd0);

    // directed lane-boundary corners
    apply(4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001); // R1 carry cut at 8
    apply(4'd0, 2'd1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001); // R1 carry ripples in 16
    apply(4'd1, 2'd2, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001); // R2 borrow stays in lane
    apply(4'd2, 2'd0, 64'h7F7F_8080_0000_0000, 64'h0101_FFFF_0000_0000); // R3
    apply(4'd3, 2'd1, 64'h8000_7FFF_0000_0000, 64'h0001_FFFF_0000_0000); // R3
    apply(4'd7, 2'd2, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF); // R6 signed order
    apply(4'd9, 2'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000); // R7 and-not

    // sweep every op/size pair
    for (int op = 0; op < 16; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int n = 0; n < 150; n++) begin
          d0 = pick_word();
          s0 = (n % 5 == 0) ? d0 : pick_word();
          apply(op[3:0], sz[1:0], d0, s0);
        end
      end
    end

    // R10: hold while idle
    apply(4'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010);
    held = ref_calc(4'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010);
    @(negedge clk);
    in_valid = 1'b0; op_code = 4'd10; dst = '1; src = '1;
    @(negedge clk);
    check("R9", "out_valid drops", {63'd0, out_valid}, 64'd0);
    check("R10", "result held (1)", result, held);
    dst = 64'h1234; op_code = 4'd1;
    @(negedge clk);
    check("R10", "result held (2)", result, held);

    // R9: reset mid-run clears out_valid
    apply(4'd11, 2'd0, 64'hAAAA, 64'h5555);
    rst_n = 1'b0;
    #1;
    check("R9", "async reset clears out_valid", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(4'd8, 2'd1, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule